// File: doc/BRIEF.md
# Quadlet-Stream CRC-16 Engine

This block computes the 16-bit check value used in the headers of bus configuration data (ROM images, topology tables, speed tables). A job begins with a one-cycle start request that carries the number of 32-bit quadlets to cover. The quadlets then arrive on a valid/ready stream. Each accepted quadlet is folded into a 16-bit check register one nibble per clock, over eight cycles. The most significant nibble goes first. Each nibble step uses a fixed xor-shift update.

When the final nibble of the final quadlet has been folded, the result appears on the result port with a one-cycle completion pulse. It stays there until the next job completes. Only one job runs at a time. Start requests that arrive while a job is running are dropped. A new job may be started in the same cycle as the completion pulse.

Top module: `quad_crc16_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `q_ready_o`, `busy_o` and `done_o` are 0 and `crc_o` is 0x0000.
- R2: The check register is cleared at every accepted start, so a job's result does not depend on any earlier job.
- R3: For each nibble `n`, the engine computes `s = chk[15:12] ^ n` and then `chk = (chk << 4) ^ (s << 12) ^ (s << 5) ^ s`, keeping the low 16 bits. Nibbles are taken from each quadlet in the order bits 31:28 first down to bits 3:0.
- R4: `q_ready_o` is high only while a job waits for its next quadlet. After each acceptance (`q_valid_i` and `q_ready_o` high at a clock edge) it is low for exactly eight cycles, and a quadlet offered during that time is not taken.
- R5: `done_o` is high for one cycle, eight cycles after the last quadlet is accepted. `crc_o` changes only in that cycle and holds afterwards. `busy_o` is high from the cycle after an accepted start until the completion cycle.
- R6: The quadlet count is sampled with the start request, and exactly that many quadlets are accepted. Counts of up to 2^CNT_W-1 are allowed.
- R7: A start with a count of 0 produces `done_o` in the next cycle with `crc_o` = 0x0000, and no quadlet is accepted.
- R8: A start request while `busy_o` is high is ignored. The running job's result and timing are unchanged.
- R9: A start request in a cycle where `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a job |
| count_i | input | CNT_W | Quadlets in the job, sampled with `start_i` |
| q_valid_i | input | 1 | Quadlet on `q_data_i` is valid |
| q_data_i | input | 32 | Quadlet to fold |
| q_ready_o | output | 1 | Engine takes the offered quadlet at this edge |
| busy_o | output | 1 | A job is in flight |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 16 | Result of the most recently completed job |

## Verification
Two events can coincide: the completion pulse of one job and the start request of the next. The bench provokes this by chaining jobs, raising `start_i` in the very cycle `done_o` is seen. Some chained jobs have a count of zero, so completions follow each other directly. Correct handling is judged on two points: `crc_o` must show the finished job's value in the pulse cycle, and the chained job must then produce its own independently computed result, which shows that its check register started from zero.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;

    localparam int QUAD_W = 32;
    localparam int NIB_W  = 4;
    localparam int CRC_W  = 16;
    localparam int NIBS_PER_QUAD = QUAD_W / NIB_W;
    localparam int NIB_IDX_W = $clog2(NIBS_PER_QUAD);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_CRUNCH = 2'd2
    } qcrc_state_e;

    // Working state of the datapath: quadlet being consumed and running check.
    typedef struct packed {
        logic [QUAD_W-1:0] shreg;
        logic [CRC_W-1:0]  chk;
    } qcrc_acc_t;

    // Strobes from the sequencer to the datapath.
    typedef struct packed {
        logic clr;
        logic load;
        logic fold;
        logic fin_fold;
        logic fin_zero;
    } qcrc_ctl_t;

    // One nibble step of the xor-shift check update.
    function automatic logic [CRC_W-1:0] qcrc_fold(input logic [CRC_W-1:0] chk,
                                                   input logic [NIB_W-1:0] nib);
        logic [NIB_W-1:0] s;
        logic [CRC_W-1:0] sw;
        s  = chk[CRC_W-1 -: NIB_W] ^ nib;
        sw = CRC_W'(s);
        return (chk << NIB_W) ^ (sw << 12) ^ (sw << 5) ^ sw;
    endfunction

endpackage

// File: rtl/qcrc_seq.sv
module qcrc_seq
    import qcrc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             q_valid_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             done_o,
    output qcrc_ctl_t        ctl_o
);

    localparam logic [NIB_IDX_W-1:0] LAST_IDX = NIB_IDX_W'(NIBS_PER_QUAD - 1);
    localparam logic [CNT_W-1:0]     ONE_LEFT = CNT_W'(1);

    qcrc_state_e          state_q;
    logic [CNT_W-1:0]     remain_q;
    logic [NIB_IDX_W-1:0] idx_q;
    logic                 done_q;

    logic take, zero_job, last_nib, last_quad;

    always_comb begin
        take       = (state_q == ST_IDLE) && start_i;
        zero_job   = take && (count_i == '0);
        ready_o    = (state_q == ST_FETCH);
        last_nib   = (state_q == ST_CRUNCH) && (idx_q == LAST_IDX);
        last_quad  = (remain_q == ONE_LEFT);
        busy_o     = (state_q != ST_IDLE);
        done_o     = done_q;

        ctl_o.clr      = take;
        ctl_o.load     = ready_o && q_valid_i;
        ctl_o.fold     = (state_q == ST_CRUNCH);
        ctl_o.fin_fold = last_nib && last_quad;
        ctl_o.fin_zero = zero_job;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= ctl_o.fin_zero || ctl_o.fin_fold;
            case (state_q)
                ST_IDLE: begin
                    if (take && !zero_job) begin
                        remain_q <= count_i;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (ctl_o.load) begin
                        idx_q   <= '0;
                        state_q <= ST_CRUNCH;
                    end
                end
                ST_CRUNCH: begin
                    idx_q <= idx_q + 1'b1;
                    if (last_nib) begin
                        if (last_quad) begin
                            state_q <= ST_IDLE;
                        end else begin
                            remain_q <= remain_q - 1'b1;
                            state_q  <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qcrc_accum.sv
module qcrc_accum
    import qcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  qcrc_ctl_t         ctl_i,
    input  logic [QUAD_W-1:0] q_data_i,
    output logic [CRC_W-1:0]  crc_o
);

    qcrc_acc_t        acc_q;
    logic [CRC_W-1:0] res_q;
    logic [NIB_W-1:0] cur_nib;
    logic [CRC_W-1:0] chk_nx;

    always_comb begin
        cur_nib = acc_q.shreg[QUAD_W-1 -: NIB_W];
        chk_nx  = qcrc_fold(acc_q.chk, cur_nib);
        crc_o   = res_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (ctl_i.clr)
                acc_q.chk <= '0;
            else if (ctl_i.fold)
                acc_q.chk <= chk_nx;

            if (ctl_i.load)
                acc_q.shreg <= q_data_i;
            else if (ctl_i.fold)
                acc_q.shreg <= acc_q.shreg << NIB_W;

            if (ctl_i.fin_zero)
                res_q <= '0;
            else if (ctl_i.fin_fold)
                res_q <= chk_nx;
        end
    end

endmodule

// File: rtl/quad_crc16_engine.sv
module quad_crc16_engine
    import qcrc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              q_valid_i,
    input  logic [QUAD_W-1:0] q_data_i,
    output logic              q_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CRC_W-1:0]  crc_o
);

    qcrc_ctl_t ctl;

    qcrc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .count_i   (count_i),
        .q_valid_i (q_valid_i),
        .ready_o   (q_ready_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .ctl_o     (ctl)
    );

    qcrc_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .q_data_i (q_data_i),
        .crc_o    (crc_o)
    );

endmodule

// File: rtl/quad_crc16_engine_chk.sv
module quad_crc16_engine_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic             q_valid_i,
    input logic             q_ready_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [15:0]      crc_o
);

    // R4: ready only inside a job
    p_ready_in_job_r4: assert property (@(posedge clk) disable iff (rst)
        q_ready_o |-> busy_o);

    // R4: an acceptance is followed by a quiet cycle while still busy
    p_accept_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (q_valid_i && q_ready_o) |=> (!q_ready_o && busy_o));

    // R7: zero count completes next cycle with zero result
    p_zero_job_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && count_i == '0) |=> (done_o && crc_o == 16'h0000));

    // R5: a job only leaves busy through the completion pulse
    p_busy_exit_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    // R5: completion is reported with the engine idle
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !q_ready_o));

    // R5: result holds outside completion cycles
    p_crc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(crc_o));

endmodule

bind quad_crc16_engine quad_crc16_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .count_i   (count_i),
    .q_valid_i (q_valid_i),
    .q_ready_o (q_ready_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .crc_o     (crc_o)
);

// File: tb/quad_crc16_engine_test.sv
module quad_crc16_engine_test;

    localparam int CNT_W = 10;
    localparam int MAXQ  = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [CNT_W-1:0] count_i;
    logic             q_valid_i;
    logic [31:0]      q_data_i;
    logic             q_ready_o;
    logic             busy_o;
    logic             done_o;
    logic [15:0]      crc_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [31:0] qbuf [0:MAXQ-1];

    always #10 clk = ~clk;

    quad_crc16_engine #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
        .q_valid_i(q_valid_i), .q_data_i(q_data_i), .q_ready_o(q_ready_o),
        .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o)
    );

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0;
        logic [3:0]  nb, sm;
        for (int q = 0; q < n; q++) begin
            for (int sh = 28; sh >= 0; sh -= 4) begin
                nb = qbuf[q][sh +: 4];
                sm = c[15:12] ^ nb;
                c  = (c << 4) ^ {sm, 12'h000} ^ {7'h00, sm, 5'h00} ^ {12'h000, sm};
            end
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Starts at a negedge; returns at the negedge where done_o is seen
    // (chain=1) or one cycle later (chain=0).
    task automatic run_job(input int n, input bit poke, input bit chain);
        logic [15:0] exp;
        exp = ref_crc(n);
        start_i = 1'b1;
        count_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            chk(done_o === 1'b1, "R7", "zero-count done", 32'(done_o), 32'd1);
            chk(crc_o === 16'h0, "R7", "zero-count crc", 32'(crc_o), 32'd0);
            chk(q_ready_o === 1'b0, "R7", "zero-count ready", 32'(q_ready_o), 32'd0);
        end else begin
            chk(busy_o === 1'b1, "R5", "busy after start", 32'(busy_o), 32'd1);
            chk(q_ready_o === 1'b1, "R4", "ready waiting", 32'(q_ready_o), 32'd1);
            for (int i = 0; i < n; i++) begin
                if (!q_valid_i) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    q_valid_i = 1'b1;
                    q_data_i  = qbuf[i];
                end
                while (!q_ready_o) @(negedge clk);
                @(negedge clk);
                // accepted; offer next quadlet early or drop valid
                if (i < n - 1 && $urandom_range(0, 1) == 1) begin
                    q_valid_i = 1'b1;
                    q_data_i  = qbuf[i+1];
                end else begin
                    q_valid_i = 1'b0;
                    q_data_i  = $urandom;
                end
                for (int j = 0; j < 8; j++) begin
                    chk(q_ready_o === 1'b0, (i == n - 1) ? "R6" : "R4",
                        "ready low while folding", 32'(q_ready_o), 32'd0);
                    chk(done_o === 1'b0, poke ? "R8" : "R5", "early done",
                        32'(done_o), 32'd0);
                    start_i = (poke && i == 0 && j == 1);
                    count_i = '0;
                    @(negedge clk);
                end
                start_i = 1'b0;
                if (i < n - 1)
                    chk(q_ready_o === 1'b1, "R4", "ready after 8 cycles",
                        32'(q_ready_o), 32'd1);
            end
            chk(done_o === 1'b1, "R5", "done after last quadlet", 32'(done_o), 32'd1);
            chk(crc_o === exp, "R3", "result", 32'(crc_o), 32'(exp));
            chk(busy_o === 1'b0, "R5", "idle at done", 32'(busy_o), 32'd0);
        end
        if (!chain) begin
            @(negedge clk);
            chk(done_o === 1'b0, "R5", "done width", 32'(done_o), 32'd0);
            chk(crc_o === exp, "R5", "result held", 32'(crc_o), 32'(exp));
            chk(q_ready_o === 1'b0, "R6", "no extra quadlet", 32'(q_ready_o), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1'b1; start_i = 1'b0; count_i = '0; q_valid_i = 1'b0; q_data_i = '0;
        repeat (3) @(negedge clk);
        chk(q_ready_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1",
            "control in reset", {29'd0, q_ready_o, busy_o, done_o}, 32'd0);
        chk(crc_o === 16'h0, "R1", "crc in reset", 32'(crc_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "after reset",
            {30'd0, busy_o, done_o}, 32'd0);

        // directed: single quadlet with a lone low bit
        qbuf[0] = 32'h0000_0001;
        run_job(1, 0, 0);
        // directed: all ones, three quadlets
        for (int k = 0; k < 3; k++) qbuf[k] = 32'hFFFF_FFFF;
        run_job(3, 0, 0);
        // R7 zero count
        run_job(0, 0, 0);
        // R8 start while busy, single and multi quadlet
        qbuf[0] = 32'h1234_5678; qbuf[1] = 32'h9ABC_DEF0;
        run_job(1, 1, 0);
        run_job(2, 1, 0);
        // R9 and R2: back-to-back jobs chained on done
        qbuf[0] = 32'hA5A5_5A5A; qbuf[1] = 32'h0F0F_F0F0;
        run_job(2, 0, 1);
        run_job(0, 0, 1);
        run_job(0, 0, 1);
        qbuf[0] = 32'h8000_0000;
        run_job(1, 0, 0);
        // full buffer
        for (int k = 0; k < MAXQ; k++) qbuf[k] = $urandom;
        run_job(MAXQ, 0, 0);
        // constrained random jobs
        for (int t = 0; t < 30; t++) begin
            int n;
            n = $urandom_range(0, 12);
            for (int k = 0; k < MAXQ; k++) qbuf[k] = $urandom;
            run_job(n, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
        end
        @(negedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule